// File: doc/BRIEF.md
# Dual-Buffer Receive Message Capture

This block stores incoming data-link messages in two equal buffers that take turns. In message mode it takes a byte stream that an upstream deframer has already cut into frames. Each byte comes with a valid strobe, start and end markers, and a flag, sampled on the last byte, that says whether the frame check passed. A frame is always written into the buffer the host is not looking at. Only a frame that completes cleanly hands that buffer over to the host. The host then sees a buffer-pointer bit and a byte count, and reads the bytes back through a select/address/data port.

In code mode the block watches a stream of short decoded codes instead. It counts how many times in a row the same code has arrived. It raises the end-of-transfer flag when that run reaches a threshold the host sets. A threshold of zero means the block listens forever and never raises the flag. The flag is sticky and the host clears it by writing a one.

Top module: `dl_rx_capture`

## Requirements
- R1: During and immediately after reset, `newest_buf` is 0, `msg_len` is 0, `eot_flag` is 0 and `frame_ovf` is 0.
- R2: In message mode (`mode_sel`=0), frame bytes are written in arrival order from address 0 into the buffer not named by `newest_buf`. When the last byte (`rx_eof`) arrives with `rx_fcs_ok`=1, `newest_buf` inverts on the following clock edge and the new buffer holds the frame.
- R3: On that same edge, `msg_len` takes the total number of bytes delivered in the frame, header and check bytes included. A frame ending with `rx_fcs_ok`=0 leaves `newest_buf` and `msg_len` unchanged.
- R4: In code mode (`mode_sel`=1), a code equal to the previous accepted code extends the run by one. A different code, or the first code since reset, restarts the run at one. The run saturates at 2^CNT_W-1. `eot_flag` sets when an advance makes the run equal `rep_thresh`, so a saturated run never sets it again.
- R5: With `rep_thresh`=0, no code ever sets `eot_flag`.
- R6: A frame may hold at most 2^CNT_W-1 bytes, and bytes past that are discarded. Such a frame gives `frame_ovf`=1 for exactly one cycle after its last byte and changes neither `newest_buf` nor `msg_len`, even with `rx_fcs_ok`=1.
- R7: In message mode, a frame that completes cleanly also sets `eot_flag`.
- R8: `eot_flag` holds until `eot_clr`=1 is seen at a clock edge. If a set and a clear arrive on the same edge, the set wins.
- R9: Codes are ignored in message mode, and frame bytes are ignored in code mode.
- R10: `host_data` presents the byte at (`host_sel`, `host_addr`) one clock edge after those inputs are sampled.
- R11: A start marker inside an open frame drops that frame and starts writing again at address 0. Bytes that arrive with no frame open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = message mode, 1 = code mode |
| rx_valid | input | 1 | Frame byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_fcs_ok | input | 1 | Frame check passed, sampled with the last byte |
| code_valid | input | 1 | Code strobe |
| code_in | input | CODE_W (6) | Decoded code |
| rep_thresh | input | CNT_W (7) | Run length that sets the flag; 0 disables it |
| eot_clr | input | 1 | Write-one-to-clear for `eot_flag` |
| host_sel | input | 1 | Buffer to read |
| host_addr | input | CNT_W (7) | Byte address to read |
| host_data | output | 8 | Read data, one cycle latency |
| newest_buf | output | 1 | Buffer holding the newest clean frame |
| msg_len | output | CNT_W (7) | Byte count of the newest clean frame |
| eot_flag | output | 1 | Sticky end-of-transfer flag |
| frame_ovf | output | 1 | One-cycle pulse after an over-long frame |

## Verification
The bench builds the block with CNT_W=4, which gives buffers of 16 bytes and a 4-bit count and threshold. At that size it can walk every legal frame length from 1 to 15 and read back every stored byte. It also tries lengths just past the limit to reach the overflow edge. In code mode it sweeps every threshold from 0 to 15, with runs long enough to reach saturation, so the zero case, each firing point and the no-refire rule are all exercised.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic {
    MODE_MSG  = 1'b0,
    MODE_CODE = 1'b1
  } dl_mode_e;

  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BYTE_W    = 8;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dlc_frame_writer.sv
module dlc_frame_writer
  import dlc_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             valid,
  input  logic             sof,
  input  logic             eof,
  input  logic             fcs_ok,
  input  byte_t            data,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output byte_t            wr_data,
  output logic             done_good,
  output logic             done_drop,
  output logic [CNT_W-1:0] done_len
);
  localparam logic [CNT_W-1:0] MAX_LEN = '1;

  logic             open_q;
  logic [CNT_W-1:0] len_q;
  logic             ovf_q;

  logic             take;
  logic [CNT_W-1:0] base_len;
  logic             base_ovf;
  logic             room;
  logic [CNT_W-1:0] next_len;
  logic             next_ovf;
  logic             last;

  always_comb begin
    take      = en && valid && (sof || open_q);
    base_len  = sof ? '0 : len_q;
    base_ovf  = sof ? 1'b0 : ovf_q;
    room      = (base_len != MAX_LEN);
    next_len  = room ? base_len + 1'b1 : base_len;
    next_ovf  = base_ovf || !room;
    last      = take && eof;
    wr_en     = take && room;
    wr_addr   = base_len;
    wr_data   = data;
    done_good = last && fcs_ok && !next_ovf;
    done_drop = last && next_ovf;
    done_len  = next_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      len_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (take) begin
      open_q <= !eof;
      len_q  <= next_len;
      ovf_q  <= next_ovf;
    end
  end
endmodule

// File: rtl/dlc_code_counter.sv
module dlc_code_counter #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  thresh,
  output logic              fire
);
  localparam logic [CNT_W-1:0] MAX_RUN = '1;

  logic [CODE_W-1:0] last_q;
  logic              seen_q;
  logic [CNT_W-1:0]  run_q;

  logic              accept;
  logic              same;
  logic              advance;
  logic [CNT_W-1:0]  run_n;

  always_comb begin
    accept  = en && valid;
    same    = seen_q && (code == last_q);
    advance = same ? (run_q != MAX_RUN) : 1'b1;
    if (!same)            run_n = CNT_W'(1);
    else if (advance)     run_n = run_q + 1'b1;
    else                  run_n = run_q;
    fire = accept && advance && (thresh != '0) && (run_n == thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else if (accept) begin
      last_q <= code;
      seen_q <= 1'b1;
      run_q  <= run_n;
    end
  end
endmodule

// File: rtl/dlc_pingpong_ram.sv
module dlc_pingpong_ram
  import dlc_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic              rbank,
  input  logic [ADDR_W-1:0] raddr,
  output byte_t             rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [NUM_BANKS-1:0][BYTE_W-1:0] bank_q;
  logic                             rsel_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    byte_t mem [DEPTH];
    byte_t q;
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b))) mem[waddr] <= wdata;
      q <= mem[raddr];
    end
    assign bank_q[b] = q;
  end

  always_ff @(posedge clk) rsel_q <= rbank;

  assign rdata = bank_q[rsel_q];
endmodule

// File: rtl/dl_rx_capture.sv
module dl_rx_capture
  import dlc_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_fcs_ok,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CNT_W-1:0]  rep_thresh,
  input  logic              eot_clr,
  input  logic              host_sel,
  input  logic [CNT_W-1:0]  host_addr,
  output logic [7:0]        host_data,
  output logic              newest_buf,
  output logic [CNT_W-1:0]  msg_len,
  output logic              eot_flag,
  output logic              frame_ovf
);
  dl_mode_e         mode;
  logic             wr_en;
  logic [CNT_W-1:0] wr_addr;
  byte_t            wr_data;
  logic             done_good;
  logic             done_drop;
  logic [CNT_W-1:0] done_len;
  logic             code_fire;

  logic             ptr_q;
  logic [CNT_W-1:0] len_q;
  logic             eot_q;
  logic             ovf_q;

  assign mode = dl_mode_e'(mode_sel);

  dlc_frame_writer #(.CNT_W(CNT_W)) u_writer (
    .clk       (clk),
    .rst       (rst),
    .en        (mode == MODE_MSG),
    .valid     (rx_valid),
    .sof       (rx_sof),
    .eof       (rx_eof),
    .fcs_ok    (rx_fcs_ok),
    .data      (rx_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done_good (done_good),
    .done_drop (done_drop),
    .done_len  (done_len)
  );

  dlc_code_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_codes (
    .clk    (clk),
    .rst    (rst),
    .en     (mode == MODE_CODE),
    .valid  (code_valid),
    .code   (code_in),
    .thresh (rep_thresh),
    .fire   (code_fire)
  );

  dlc_pingpong_ram #(.ADDR_W(CNT_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .wbank (~ptr_q),
    .waddr (wr_addr),
    .wdata (wr_data),
    .rbank (host_sel),
    .raddr (host_addr),
    .rdata (host_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= 1'b0;
      len_q <= '0;
      eot_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= done_drop;
      if (done_good) begin
        ptr_q <= ~ptr_q;
        len_q <= done_len;
      end
      if (done_good || code_fire) eot_q <= 1'b1;
      else if (eot_clr)           eot_q <= 1'b0;
    end
  end

  assign newest_buf = ptr_q;
  assign msg_len    = len_q;
  assign eot_flag   = eot_q;
  assign frame_ovf  = ovf_q;
endmodule

// File: rtl/dl_rx_capture_chk.sv
module dl_rx_capture_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_sel,
  input logic             rx_valid,
  input logic             rx_eof,
  input logic             rx_fcs_ok,
  input logic [CNT_W-1:0] rep_thresh,
  input logic             eot_clr,
  input logic             newest_buf,
  input logic [CNT_W-1:0] msg_len,
  input logic             eot_flag,
  input logic             frame_ovf
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!newest_buf && msg_len == '0 && !eot_flag && !frame_ovf)); // R1

  AST_PTR_ON_GOOD_END: assert property (@(posedge clk) disable iff (rst)
    (newest_buf != $past(newest_buf)) |->
      $past(rx_valid && rx_eof && rx_fcs_ok && !mode_sel)); // R2

  AST_LEN_NONZERO_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
    (newest_buf != $past(newest_buf)) |-> (msg_len != '0)); // R3

  AST_ZERO_THR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && rep_thresh == '0 && !eot_flag) |=> !eot_flag); // R5

  AST_OVF_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    frame_ovf |-> ($stable(newest_buf) && $stable(msg_len))); // R6

  AST_OVF_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    frame_ovf |-> $past(rx_valid && rx_eof && !mode_sel)); // R6

  AST_EOT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (eot_flag && !eot_clr) |=> eot_flag); // R8
endmodule

bind dl_rx_capture dl_rx_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .rx_valid   (rx_valid),
  .rx_eof     (rx_eof),
  .rx_fcs_ok  (rx_fcs_ok),
  .rep_thresh (rep_thresh),
  .eot_clr    (eot_clr),
  .newest_buf (newest_buf),
  .msg_len    (msg_len),
  .eot_flag   (eot_flag),
  .frame_ovf  (frame_ovf)
);

// File: tb/dl_rx_capture_tb.sv
module dl_rx_capture_tb;
  localparam int CNT_W  = 4;
  localparam int CODE_W = 6;
  localparam int MAXL   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_fcs_ok = 1'b0;
  logic [7:0] rx_data = '0;
  logic code_valid = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic [CNT_W-1:0] rep_thresh = '0;
  logic eot_clr = 1'b0;
  logic host_sel = 1'b0;
  logic [CNT_W-1:0] host_addr = '0;
  logic [7:0] host_data;
  logic newest_buf;
  logic [CNT_W-1:0] msg_len;
  logic eot_flag;
  logic frame_ovf;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] bm [0:1][0:MAXL];
  int exp_ptr = 0, exp_cnt = 0, exp_eot = 0;
  int m_last = 0, m_seen = 0, m_run = 0;

  always #5 clk = ~clk;

  dl_rx_capture #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_fcs_ok(rx_fcs_ok),
    .code_valid(code_valid), .code_in(code_in), .rep_thresh(rep_thresh),
    .eot_clr(eot_clr), .host_sel(host_sel), .host_addr(host_addr),
    .host_data(host_data), .newest_buf(newest_buf), .msg_len(msg_len),
    .eot_flag(eot_flag), .frame_ovf(frame_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check_state(input string req, input int ovf);
    chk({req, " ptr"}, int'(newest_buf), exp_ptr);
    chk({req, " len"}, int'(msg_len), exp_cnt);
    chk({req, " eot"}, int'(eot_flag), exp_eot);
    chk({req, " ovf"}, int'(frame_ovf), ovf);
  endtask

  task automatic clear_eot();
    @(negedge clk); eot_clr = 1'b1;
    @(negedge clk); eot_clr = 1'b0;
    exp_eot = 0;
    chk("R8 clear", int'(eot_flag), 0);
  endtask

  task automatic send_frame(input int len, input bit fcs, input int seed, input bit clr_last);
    int wb;
    int ovf;
    wb = (exp_ptr == 0) ? 1 : 0;
    ovf = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_fcs_ok = fcs; rx_data = pat(seed, i);
      eot_clr = clr_last && (i == len - 1);
      if (!mode_sel && i < MAXL) bm[wb][i] = pat(seed, i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; eot_clr = 1'b0;
    if (!mode_sel) begin
      if (len > MAXL) ovf = 1;
      else if (fcs) begin exp_ptr = 1 - exp_ptr; exp_cnt = len; exp_eot = 1; end
      else if (clr_last) exp_eot = 0;
    end else if (clr_last) exp_eot = 0;
    check_state("R2 R3 R6 R7 frame", ovf);
  endtask

  task automatic verify_buf(input int len, input string req);
    for (int a = 0; a < len; a++) begin
      @(negedge clk); host_sel = 1'(exp_ptr); host_addr = CNT_W'(a);
      @(negedge clk);
      chk(req, int'(host_data), int'(bm[exp_ptr][a]));
    end
  endtask

  task automatic send_code(input int c);
    @(negedge clk); code_valid = 1'b1; code_in = CODE_W'(c);
    @(negedge clk); code_valid = 1'b0;
    if (mode_sel) begin
      int adv;
      if (m_seen != 0 && c == m_last) begin
        adv = (m_run != MAXL) ? 1 : 0;
        if (adv != 0) m_run++;
      end else begin
        adv = 1; m_run = 1;
      end
      m_last = c; m_seen = 1;
      if (adv != 0 && int'(rep_thresh) != 0 && m_run == int'(rep_thresh)) exp_eot = 1;
    end
    chk("R4 R5 R9 code", int'(eot_flag), exp_eot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 in reset", 0);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 after reset", 0);

    // R2 R3 R7 R10: every legal length, readback, then clear
    for (int l = 1; l <= MAXL; l++) begin
      send_frame(l, 1'b1, l, 1'b0);
      verify_buf(l, "R2 R10 readback");
      clear_eot();
    end

    // R3: bad check flag leaves pointer and length
    send_frame(3, 1'b0, 40, 1'b0);
    send_frame(9, 1'b0, 41, 1'b0);
    verify_buf(exp_cnt, "R3 newest intact");

    // R6: over-long frames
    for (int l = MAXL + 1; l <= MAXL + 3; l++) begin
      send_frame(l, 1'b1, 50 + l, 1'b0);
      @(negedge clk);
      chk("R6 ovf one cycle", int'(frame_ovf), 0);
    end
    verify_buf(exp_cnt, "R6 newest intact");
    send_frame(MAXL, 1'b1, 60, 1'b0);
    verify_buf(MAXL, "R6 full frame after ovf");

    // R8: set wins over clear
    send_frame(2, 1'b1, 61, 1'b1);
    clear_eot();

    // R11: restart inside an open frame
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'hEE;
      bm[1 - exp_ptr][i] = 8'hEE;
    end
    send_frame(4, 1'b1, 70, 1'b0);
    chk("R11 restart len", int'(msg_len), 4);
    verify_buf(4, "R11 restart data");
    clear_eot();
    // R11: bytes with no open frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_fcs_ok = 1'b1; rx_data = 8'h11;
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    check_state("R11 stray bytes", 0);

    // R9: codes ignored in message mode
    rep_thresh = CNT_W'(1);
    send_code(5);
    send_code(5);

    // R9: frames ignored in code mode
    mode_sel = 1'b1;
    rep_thresh = '0;
    send_frame(3, 1'b1, 80, 1'b0);

    // R4 R5: every threshold
    for (int t = 0; t <= MAXL; t++) begin
      rep_thresh = CNT_W'(t);
      clear_eot();
      for (int k = 0; k < MAXL + 3; k++) send_code((t * 3 + 1) & 63);
    end

    // R4: restart on a different code
    rep_thresh = CNT_W'(3);
    clear_eot();
    send_code(7); send_code(7); send_code(9); send_code(9);
    chk("R4 restart no fire", int'(eot_flag), 0);
    send_code(9);
    chk("R4 restart fires", int'(eot_flag), 1);

    // R4: saturated run does not fire again
    rep_thresh = CNT_W'(MAXL);
    clear_eot();
    for (int k = 0; k < MAXL; k++) send_code(20);
    chk("R4 fire at max", int'(eot_flag), 1);
    clear_eot();
    for (int k = 0; k < 5; k++) send_code(20);
    chk("R4 no refire", int'(eot_flag), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule